// File: doc/BRIEF.md
# Protected Non-Volatile Memory Command Controller

This block is the command and protection front end of a word-organised non-volatile store. A small register array stands in for the storage cells. Three modifying commands are accepted:

- programming of one word;
- programming of a whole aligned group of words from a staging buffer, timed at half the per-word cost;
- erasure of one sector.

Programming can only clear bits. Erasure sets every bit of the chosen sector back to one.

Protection is set per region, and each region covers two adjacent erase sectors. A region can be made read-only, which blocks every program and erase aimed at it. It can instead be made fetch-only, which also blocks modification and, in addition, hides its contents from every read except one tagged as an instruction fetch.

Errors are reported through two flags. A blocked operation raises a sticky protection-violation flag. A command issued while an operation is in progress, or a buffered program at a misaligned address, raises a sticky command-error flag. Both flags stay set until reset.

Top module: `flash_prot_ctrl`

## Requirements
- R1: After reset, `busy`, `prot_viol`, `cmd_err` and `rd_data` are 0, and every stored word reads as all ones.
- R2: A single-word program (`cmd_op` = 2'b01) stores the bitwise AND of the old word and `cmd_data`. `busy` is high for exactly PROG_CYC cycles, starting the cycle after acceptance, and the new value is readable once `busy` falls.
- R3: A buffered program (`cmd_op` = 2'b10) ANDs each buffer entry k (loaded through `buf_wr`/`buf_idx`/`buf_data`) into word `cmd_addr`+k, for k = 0..BURST_WORDS-1. `busy` is high for BURST_WORDS*PROG_CYC/2 cycles.
- R4: A sector erase (`cmd_op` = 2'b11) sets every word of the sector holding `cmd_addr` to all ones and leaves other sectors unchanged. `busy` is high for ERASE_CYC cycles.
- R5: Any program or erase that targets a region marked in `prot_ro` or `prot_xo` has no effect. `busy` stays low and `prot_viol` is 1 on the next cycle. Region index = `cmd_addr` / (2*SECTOR_WORDS).
- R6: A read with `rd_fetch`=0 of a region marked in `prot_xo` returns 0 and sets `prot_viol`. A read with `rd_fetch`=1 of that region, and any read of a read-only region, returns the stored word.
- R7: A command issued while `busy` is high is discarded, and `cmd_err` is 1 on the next cycle.
- R8: A buffered program whose `cmd_addr` is not a multiple of BURST_WORDS is rejected as a whole. Nothing is written, `busy` stays low and `cmd_err` is 1 on the next cycle.
- R9: `rd_data` is registered and is valid one cycle after `rd_en`. `prot_viol` and `cmd_err` remain 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request strobe |
| cmd_op | input | 2 | 01 word program, 10 buffered program, 11 sector erase, 00 none |
| cmd_addr | input | AW | Target word address |
| cmd_data | input | DATA_W | Data for single-word program |
| buf_wr | input | 1 | Write one staging-buffer entry (ignored while busy) |
| buf_idx | input | BB | Staging-buffer entry index |
| buf_data | input | DATA_W | Staging-buffer entry data |
| prot_ro | input | NUM_REGIONS | Read-only mark per region |
| prot_xo | input | NUM_REGIONS | Fetch-only mark per region |
| rd_en | input | 1 | Read request |
| rd_fetch | input | 1 | Read is an instruction fetch |
| rd_addr | input | AW | Read word address |
| rd_data | output | DATA_W | Read result, one cycle after request |
| busy | output | 1 | Program or erase in progress |
| prot_viol | output | 1 | Sticky protection-violation flag |
| cmd_err | output | 1 | Sticky busy/misalignment command error |

## Verification
A wrong sequencer count shows immediately at `busy`. The high window ends one or more cycles early or late against the length set by the operation, and this is visible on the first command of each kind. A wrong address compare in the write path is different: it stays hidden until a later read of the affected word, or of a neighbouring word in another sector or buffer group. The bench therefore reads back both the target and untouched neighbours after each operation. A faulty region decode shows within one cycle, as a missing or spurious flag, or as a blocked read that returns nonzero data.

// File: rtl/flash_pkg.sv
package flash_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_WORD  = 2'b01,
      OP_BURST = 2'b10,
      OP_ERASE = 2'b11
   } fop_e;
endpackage

// File: rtl/flash_region_gate.sv
// Decodes the protection region of an address and reports what it permits.
module flash_region_gate #(
   parameter int AW    = 5,
   parameter int RLO   = 4,
   parameter int NREG  = 2
) (
   input  logic [AW-1:0]   addr,
   input  logic            fetch,
   input  logic [NREG-1:0] ro,
   input  logic [NREG-1:0] xo,
   output logic            read_ok,
   output logic            modify_ok
);
   logic [AW-RLO-1:0] region;

   assign region    = addr[AW-1:RLO];
   assign read_ok   = !xo[region] || fetch;
   assign modify_ok = !(ro[region] || xo[region]);
endmodule

// File: rtl/flash_wbuf.sv
// Staging buffer for grouped programming; entries reset to all ones.
module flash_wbuf #(
   parameter int W     = 32,
   parameter int DEPTH = 4,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [IW-1:0]             idx,
   input  logic [W-1:0]              din,
   output logic [DEPTH-1:0][W-1:0]   q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '1;
      end else if (wr_en) begin
         q[idx] <= din;
      end
   end
endmodule

// File: rtl/flash_op_seq.sv
// Operation timer: holds busy for the cycle count of the accepted operation.
module flash_op_seq
   import flash_pkg::*;
#(
   parameter int PROG_CYC  = 4,
   parameter int BURST_CYC = 8,
   parameter int ERASE_CYC = 12,
   parameter int CW        = 8
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start,
   input  fop_e  start_op,
   output logic  busy,
   output logic  done,
   output fop_e  cur_op
);
   logic [CW-1:0] cnt;
   logic [CW-1:0] load_val;

   always_comb begin
      case (start_op)
         OP_WORD:  load_val = CW'(PROG_CYC - 1);
         OP_BURST: load_val = CW'(BURST_CYC - 1);
         OP_ERASE: load_val = CW'(ERASE_CYC - 1);
         default:  load_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         cur_op <= OP_NONE;
      end else if (start) begin
         busy   <= 1'b1;
         cnt    <= load_val;
         cur_op <= start_op;
      end else if (busy) begin
         if (cnt == '0) begin
            busy <= 1'b0;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   assign done = busy && (cnt == '0);
endmodule

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl
   import flash_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int SECTOR_WORDS = 8,
   parameter int NUM_SECTORS  = 4,
   parameter int BURST_WORDS  = 4,
   parameter int PROG_CYC     = 4,
   parameter int ERASE_CYC    = 12,
   localparam int WORDS       = SECTOR_WORDS * NUM_SECTORS,
   localparam int AW          = $clog2(WORDS),
   localparam int SB          = $clog2(SECTOR_WORDS),
   localparam int RLO         = SB + 1,
   localparam int BB          = $clog2(BURST_WORDS),
   localparam int NUM_REGIONS = NUM_SECTORS / 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid,
   input  logic [1:0]             cmd_op,
   input  logic [AW-1:0]          cmd_addr,
   input  logic [DATA_W-1:0]      cmd_data,
   input  logic                   buf_wr,
   input  logic [BB-1:0]          buf_idx,
   input  logic [DATA_W-1:0]      buf_data,
   input  logic [NUM_REGIONS-1:0] prot_ro,
   input  logic [NUM_REGIONS-1:0] prot_xo,
   input  logic                   rd_en,
   input  logic                   rd_fetch,
   input  logic [AW-1:0]          rd_addr,
   output logic [DATA_W-1:0]      rd_data,
   output logic                   busy,
   output logic                   prot_viol,
   output logic                   cmd_err
);
   localparam int BURST_CYC = (BURST_WORDS * PROG_CYC) / 2;
   localparam int MAX_CYC   = (ERASE_CYC > BURST_CYC)
                              ? ((ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC)
                              : ((BURST_CYC > PROG_CYC) ? BURST_CYC : PROG_CYC);
   localparam int CW        = $clog2(MAX_CYC + 1);

   // Elaboration-time parameter checks
   if (NUM_SECTORS < 4 || (NUM_SECTORS & (NUM_SECTORS - 1)) != 0)
      $error("NUM_SECTORS must be a power of two, at least 4");
   if (SECTOR_WORDS < 2 || (SECTOR_WORDS & (SECTOR_WORDS - 1)) != 0)
      $error("SECTOR_WORDS must be a power of two, at least 2");
   if (BURST_WORDS < 2 || (BURST_WORDS & (BURST_WORDS - 1)) != 0 || BURST_WORDS > SECTOR_WORDS)
      $error("BURST_WORDS must be a power of two in 2..SECTOR_WORDS");
   if (PROG_CYC < 1 || ERASE_CYC < 1 || ((BURST_WORDS * PROG_CYC) % 2) != 0)
      $error("cycle counts must be positive and BURST_WORDS*PROG_CYC even");

   fop_e                        op_in;
   fop_e                        cur_op;
   logic                        seq_busy;
   logic                        seq_done;
   logic                        cmd_req;
   logic                        cmd_mod_ok;
   logic                        rd_ok;
   logic                        unused_fetch_ok;
   logic                        misaligned;
   logic                        start;
   logic [AW-1:0]               lat_addr;
   logic [DATA_W-1:0]           lat_data;
   logic [BURST_WORDS-1:0][DATA_W-1:0] buf_q;
   logic [WORDS-1:0][DATA_W-1:0]       mem;
   logic [WORDS-1:0][DATA_W-1:0]       mem_nxt;

   assign op_in      = fop_e'(cmd_op);
   assign cmd_req    = cmd_valid && (op_in != OP_NONE);
   assign misaligned = (op_in == OP_BURST) && (cmd_addr[BB-1:0] != '0);
   assign start      = cmd_req && !seq_busy && cmd_mod_ok && !misaligned;

   // Protection decode for the command address and the read address
   flash_region_gate #(.AW(AW), .RLO(RLO), .NREG(NUM_REGIONS)) u_cmd_gate (
      .addr      (cmd_addr),
      .fetch     (1'b0),
      .ro        (prot_ro),
      .xo        (prot_xo),
      .read_ok   (unused_fetch_ok),
      .modify_ok (cmd_mod_ok)
   );

   logic unused_rd_mod;
   flash_region_gate #(.AW(AW), .RLO(RLO), .NREG(NUM_REGIONS)) u_rd_gate (
      .addr      (rd_addr),
      .fetch     (rd_fetch),
      .ro        (prot_ro),
      .xo        (prot_xo),
      .read_ok   (rd_ok),
      .modify_ok (unused_rd_mod)
   );

   flash_wbuf #(.W(DATA_W), .DEPTH(BURST_WORDS)) u_wbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (buf_wr && !seq_busy),
      .idx   (buf_idx),
      .din   (buf_data),
      .q     (buf_q)
   );

   flash_op_seq #(
      .PROG_CYC (PROG_CYC),
      .BURST_CYC(BURST_CYC),
      .ERASE_CYC(ERASE_CYC),
      .CW       (CW)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .start_op (op_in),
      .busy     (seq_busy),
      .done     (seq_done),
      .cur_op   (cur_op)
   );

   // Command operands captured at acceptance
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_addr <= '0;
         lat_data <= '0;
      end else if (start) begin
         lat_addr <= cmd_addr;
         lat_data <= cmd_data;
      end
   end

   // Per-word next value, applied when the timed operation completes
   for (genvar i = 0; i < WORDS; i++) begin : g_word
      localparam logic [AW-1:0] IA = AW'(i);
      logic hit_word, hit_group, hit_sector;

      assign hit_word   = (IA == lat_addr);
      assign hit_group  = (IA[AW-1:BB] == lat_addr[AW-1:BB]);
      assign hit_sector = (IA[AW-1:SB] == lat_addr[AW-1:SB]);

      always_comb begin
         mem_nxt[i] = mem[i];
         case (cur_op)
            OP_WORD:  if (hit_word)   mem_nxt[i] = mem[i] & lat_data;
            OP_BURST: if (hit_group)  mem_nxt[i] = mem[i] & buf_q[i % BURST_WORDS];
            OP_ERASE: if (hit_sector) mem_nxt[i] = '1;
            default:  mem_nxt[i] = mem[i];
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem <= '1;
      end else if (seq_done) begin
         mem <= mem_nxt;
      end
   end

   // Read port and sticky flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data   <= '0;
         prot_viol <= 1'b0;
         cmd_err   <= 1'b0;
      end else begin
         if (rd_en) begin
            rd_data <= rd_ok ? mem[rd_addr] : '0;
         end
         if ((rd_en && !rd_ok) || (cmd_req && !seq_busy && !cmd_mod_ok)) begin
            prot_viol <= 1'b1;
         end
         if (cmd_req && (seq_busy || (cmd_mod_ok && misaligned))) begin
            cmd_err <= 1'b1;
         end
      end
   end

   assign busy = seq_busy;
endmodule

// File: rtl/flash_prot_ctrl_chk.sv
module flash_prot_ctrl_chk #(
   parameter int AW          = 5,
   parameter int RLO         = 4,
   parameter int BB          = 2,
   parameter int NREG        = 2,
   parameter int DATA_W      = 32,
   parameter int PROG_CYC    = 4,
   parameter int BURST_WORDS = 4,
   parameter int ERASE_CYC   = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [1:0]        cmd_op,
   input logic [AW-1:0]     cmd_addr,
   input logic [NREG-1:0]   prot_ro,
   input logic [NREG-1:0]   prot_xo,
   input logic              rd_en,
   input logic              rd_fetch,
   input logic [AW-1:0]     rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              busy,
   input logic              prot_viol,
   input logic              cmd_err
);
   logic [15:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run <= '0;
      else if (busy) run <= run + 1'b1;
      else           run <= '0;
   end

   // R2 R3 R4: every busy window has one of the three operation lengths
   assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run == 16'(PROG_CYC) || run == 16'(BURST_WORDS * PROG_CYC / 2)
                       || run == 16'(ERASE_CYC)));

   assert_prot_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op != 2'b00 && !busy &&
       (prot_ro[cmd_addr[AW-1:RLO]] || prot_xo[cmd_addr[AW-1:RLO]]))
      |=> (!busy && prot_viol));

   assert_xo_hidden_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_fetch && prot_xo[rd_addr[AW-1:RLO]]) |=> (rd_data == '0 && prot_viol));

   assert_busy_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op != 2'b00 && busy) |=> cmd_err);

   assert_misalign_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'b10 && !busy && cmd_addr[BB-1:0] != '0 &&
       !prot_ro[cmd_addr[AW-1:RLO]] && !prot_xo[cmd_addr[AW-1:RLO]])
      |=> (!busy && cmd_err));

   assert_viol_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      prot_viol |=> prot_viol);

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |=> cmd_err);
endmodule

bind flash_prot_ctrl flash_prot_ctrl_chk #(
   .AW(AW), .RLO(RLO), .BB(BB), .NREG(NUM_REGIONS), .DATA_W(DATA_W),
   .PROG_CYC(PROG_CYC), .BURST_WORDS(BURST_WORDS), .ERASE_CYC(ERASE_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .cmd_addr(cmd_addr), .prot_ro(prot_ro), .prot_xo(prot_xo), .rd_en(rd_en),
   .rd_fetch(rd_fetch), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
   .prot_viol(prot_viol), .cmd_err(cmd_err)
);

// File: tb/sim_flash_prot_ctrl.sv
module sim_flash_prot_ctrl;
   localparam int AW = 5;
   localparam int NR = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'b00;
   logic [AW-1:0] cmd_addr = '0;
   logic [31:0]   cmd_data = '0;
   logic          buf_wr = 1'b0;
   logic [1:0]    buf_idx = '0;
   logic [31:0]   buf_data = '0;
   logic [NR-1:0] prot_ro = '0;
   logic [NR-1:0] prot_xo = '0;
   logic          rd_en = 1'b0;
   logic          rd_fetch = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [31:0]   rd_data;
   logic          busy, prot_viol, cmd_err;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   flash_prot_ctrl u0 (.*);

   // Vector fields: op[78:77] addr[76:72] data[71:40] expected[39:8] cycles[7:0]
   localparam int NV = 5;
   localparam logic [78:0] VEC [NV] = '{
      {2'b01, 5'd3,  32'hF0F0_FFFF, 32'hF0F0_FFFF, 8'd4},
      {2'b01, 5'd3,  32'hFFFF_00FF, 32'hF0F0_00FF, 8'd4},
      {2'b01, 5'd10, 32'h1234_5678, 32'h1234_5678, 8'd4},
      {2'b11, 5'd9,  32'h0000_0000, 32'hFFFF_FFFF, 8'd12},
      {2'b01, 5'd31, 32'h0000_0000, 32'h0000_0000, 8'd4}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cmd_valid = 1'b0; buf_wr = 1'b0; rd_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_cmd(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [31:0] d, output int cyc);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'b00;
      cyc = 0;
      while (busy) begin
         cyc++;
         @(negedge clk);
      end
   endtask

   task automatic do_rd(input logic [AW-1:0] a, input logic f, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a; rd_fetch = f;
      @(negedge clk);
      rd_en = 1'b0; rd_fetch = 1'b0;
      d = rd_data;
   endtask

   task automatic load_buf(input logic [1:0] i, input logic [31:0] d);
      @(negedge clk);
      buf_wr = 1'b1; buf_idx = i; buf_data = d;
      @(negedge clk);
      buf_wr = 1'b0;
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int cyc;
      logic [31:0] d;

      do_reset();
      // R1 reset state
      chk("R1 busy", 32'(busy), 0);
      chk("R1 prot_viol", 32'(prot_viol), 0);
      chk("R1 cmd_err", 32'(cmd_err), 0);
      chk("R1 rd_data", rd_data, 0);
      do_rd(5'd17, 1'b0, d);
      chk("R1 erased word", d, 32'hFFFF_FFFF);

      // R2 R4 vector walk: command, busy length, read-back
      for (int v = 0; v < NV; v++) begin
         do_cmd(VEC[v][78:77], VEC[v][76:72], VEC[v][71:40], cyc);
         chk("R2/R4 busy cycles", 32'(cyc), 32'(VEC[v][7:0]));
         do_rd(VEC[v][76:72], 1'b0, d);
         chk("R2/R4 readback", d, VEC[v][39:8]);
      end
      // R4 erase hit only its own sector
      do_rd(5'd10, 1'b0, d);
      chk("R4 sector word cleared to ones", d, 32'hFFFF_FFFF);
      do_rd(5'd3, 1'b0, d);
      chk("R4 other sector kept", d, 32'hF0F0_00FF);

      // R3 buffered program
      load_buf(2'd0, 32'h1111_1111);
      load_buf(2'd1, 32'h2222_2222);
      load_buf(2'd2, 32'h3333_3333);
      load_buf(2'd3, 32'h4444_4444);
      do_cmd(2'b10, 5'd20, 32'h0, cyc);
      chk("R3 burst cycles", 32'(cyc), 8);
      for (int k = 0; k < 4; k++) begin
         do_rd(5'(20 + k), 1'b0, d);
         chk("R3 burst word", d, {8{4'(k + 1)}});
      end
      do_rd(5'd24, 1'b0, d);
      chk("R3 neighbour untouched", d, 32'hFFFF_FFFF);

      // R8 misaligned burst
      chk("R8 no error before", 32'(cmd_err), 0);
      do_cmd(2'b10, 5'd17, 32'h0, cyc);
      chk("R8 busy stays low", 32'(cyc), 0);
      chk("R8 cmd_err", 32'(cmd_err), 1);
      do_rd(5'd17, 1'b0, d);
      chk("R8 word unchanged", d, 32'hFFFF_FFFF);
      chk("R9 cmd_err sticky", 32'(cmd_err), 1);

      // R7 command while busy
      do_reset();
      chk("R9 reset clears cmd_err", 32'(cmd_err), 0);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b11; cmd_addr = 5'd0;
      @(negedge clk);
      cmd_op = 2'b01; cmd_addr = 5'd20; cmd_data = 32'h0;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'b00;
      chk("R7 cmd_err", 32'(cmd_err), 1);
      while (busy) @(negedge clk);
      do_rd(5'd20, 1'b0, d);
      chk("R7 rejected program had no effect", d, 32'hFFFF_FFFF);

      // R5 read-only region
      do_reset();
      prot_ro = 2'b01;
      do_cmd(2'b01, 5'd2, 32'h0, cyc);
      chk("R5 busy stays low", 32'(cyc), 0);
      chk("R5 prot_viol", 32'(prot_viol), 1);
      do_rd(5'd2, 1'b0, d);
      chk("R6 read-only region readable", d, 32'hFFFF_FFFF);
      do_reset();
      do_cmd(2'b11, 5'd1, 32'h0, cyc);
      chk("R5 erase blocked", 32'(cyc), 0);
      chk("R5 erase prot_viol", 32'(prot_viol), 1);
      do_cmd(2'b01, 5'd18, 32'h0000_FFFF, cyc);
      chk("R5 unprotected region programs", 32'(cyc), 4);
      prot_ro = 2'b00;

      // R6 fetch-only region
      do_reset();
      do_cmd(2'b01, 5'd20, 32'hA5A5_A5A5, cyc);
      prot_xo = 2'b10;
      do_rd(5'd20, 1'b1, d);
      chk("R6 fetch read data", d, 32'hA5A5_A5A5);
      chk("R6 fetch no violation", 32'(prot_viol), 0);
      do_rd(5'd20, 1'b0, d);
      chk("R6 data read blocked", d, 32'h0);
      chk("R6 data read violation", 32'(prot_viol), 1);
      repeat (3) @(negedge clk);
      chk("R9 prot_viol sticky", 32'(prot_viol), 1);

      // R5 buffered program into fetch-only region
      do_reset();
      load_buf(2'd0, 32'h0);
      do_cmd(2'b10, 5'd16, 32'h0, cyc);
      chk("R5 burst blocked", 32'(cyc), 0);
      chk("R5 burst prot_viol", 32'(prot_viol), 1);
      do_rd(5'd16, 1'b1, d);
      chk("R5 burst target unchanged", d, 32'hFFFF_FFFF);
      prot_xo = 2'b00;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule